// File: doc/BRIEF.md
# Latency-Budgeted Pipelined Multiplier with Sync Side-Channel

This block multiplies two unsigned operands for a pixel-processing datapath and returns the full-width product. Each operand is split into low and high halves. The four half-by-half partial products are registered in the first stage. The two cross terms are added in the second stage, and the 64-bit result is assembled in the third stage. A small bundle of sync bits, such as line and frame markers, travels alongside the arithmetic. A valid flag travels with it too. All of them leave on the same cycle as the product they belong to.

The integrator chooses the total latency through a parameter. When the budget is larger than the three intrinsic stages, extra register stages are appended until the latency matches exactly. This lets the caller balance parallel paths by arithmetic alone. A budget smaller than three stops elaboration with a fatal error. One active-high enable advances every stage at once. When it is low, the arithmetic, the valid flags and the sync bits all freeze together, so they can never slip apart.

Top module: `pix_mul_budget`

## Requirements
- R1: `product` equals the unsigned full-width product `a * b` of the operands captured together with it.
- R2: A sample captured at an enabled rising edge appears on the outputs right after the LATENCY-th enabled rising edge, counting the capturing edge as the first. The default LATENCY is 5 and the intrinsic depth is 3.
- R3: `out_side` presents the `in_side` bits that were captured on the same edge as the operands of the current `product`.
- R4: `out_valid` is 1 exactly for results whose input was captured with `in_valid` = 1, and 0 otherwise.
- R5: While `en` is 0 (and `rst` is 0), no stage advances. `product`, `out_side` and `out_valid` keep their values, and the cycles spent stalled do not count toward the latency.
- R6: A synchronous `rst` = 1 clears every in-flight valid flag, whatever the value of `en`. `out_valid` is 0 after the reset edge, and it stays 0 until a new valid sample has passed through all stages.
- R7: Corner operands give exact results. A zero operand gives 0. All-ones times all-ones gives 0xFFFFFFFE00000001. 0x00010000 squared gives 0x0000000100000000, which carries across the half boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| en | input | 1 | Pipeline advance enable; 0 stalls every stage |
| in_valid | input | 1 | Marks the operands on `a`/`b` as a real sample |
| a | input | OP_W (32) | Unsigned multiplicand |
| b | input | OP_W (32) | Unsigned multiplier |
| in_side | input | SIDE_W (2) | Sync bits carried alongside the sample |
| out_valid | output | 1 | Marks `product` and `out_side` as a real result |
| product | output | 2*OP_W (64) | Unsigned product |
| out_side | output | SIDE_W (2) | Sync bits matching `product` |

## Verification
Every result is due a fixed number of enabled edges after its capture: five by default. Stalled cycles add to the wall-clock delay but not to that count. The bench keeps its own delay line of expected operands, sync bits and valid flags, and advances it only on edges where `en` was high. It compares the outputs against the tail of that line at each falling edge, so each comparison lands in the cycle the result should appear. On cycles that follow a stalled edge, the bench also requires every output to equal its value from the previous falling edge.

// File: rtl/pix_mul_pkg.sv
package pix_mul_pkg;
  // Register stages the arithmetic needs before any padding is added.
  localparam int unsigned CORE_DEPTH = 3;

  // Number of padding stages needed to reach a given latency budget.
  function automatic int unsigned pad_depth(input int unsigned budget);
    return (budget > CORE_DEPTH) ? (budget - CORE_DEPTH) : 0;
  endfunction
endpackage

// File: rtl/pmb_split_stage.sv
// Stage 1: splits the operands into halves and registers the four partial products.
module pmb_split_stage #(
  parameter int OP_W   = 32,
  parameter int SIDE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      in_valid,
  input  logic [OP_W-1:0]           a,
  input  logic [OP_W-1:0]           b,
  input  logic [SIDE_W-1:0]         in_side,
  output logic [3:0][OP_W-1:0]      pp_q,
  output logic [SIDE_W-1:0]         side_q,
  output logic                      valid_q
);
  localparam int HALF = OP_W / 2;

  // Index k: bit 1 picks the half of a, bit 0 picks the half of b.
  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        pp_q[k] <= OP_W'(a[(k / 2) * HALF +: HALF]) * OP_W'(b[(k % 2) * HALF +: HALF]);
      end
      side_q <= in_side;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     valid_q <= 1'b0;
    else if (en) valid_q <= in_valid;
  end

  // R4: a sample's valid flag enters the pipe only on an enabled edge.
  assert_capture_valid_R4: assert property (@(posedge clk) disable iff (rst)
    en |=> (valid_q == $past(in_valid)));

  // R5: a stalled edge leaves the partial products and sync bits untouched.
  assert_split_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pp_q) && $stable(side_q) && $stable(valid_q)));
endmodule

// File: rtl/pmb_sum_stages.sv
// Stages 2 and 3: add the cross terms, then assemble the full-width sum.
module pmb_sum_stages #(
  parameter int OP_W   = 32,
  parameter int SIDE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [3:0][OP_W-1:0]      pp_in,
  input  logic [SIDE_W-1:0]         side_in,
  input  logic                      valid_in,
  output logic [2*OP_W-1:0]         prod_q,
  output logic [SIDE_W-1:0]         side_q,
  output logic                      valid_q
);
  localparam int HALF = OP_W / 2;
  localparam int PW   = 2 * OP_W;

  logic [OP_W:0]     mid_q;
  logic [OP_W-1:0]   lo_q;
  logic [OP_W-1:0]   hi_q;
  logic [SIDE_W-1:0] side2_q;
  logic              valid2_q;

  // Stage 2: the cross terms are summed one bit wider to keep their carry.
  always_ff @(posedge clk) begin
    if (en) begin
      mid_q   <= (OP_W+1)'(pp_in[1]) + (OP_W+1)'(pp_in[2]);
      lo_q    <= pp_in[0];
      hi_q    <= pp_in[3];
      side2_q <= side_in;
    end
  end

  // Stage 3: the outer terms are concatenated, and the shifted middle term is added.
  always_ff @(posedge clk) begin
    if (en) begin
      prod_q <= {hi_q, lo_q} + (PW'(mid_q) << HALF);
      side_q <= side2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid2_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (en) begin
      valid2_q <= valid_in;
      valid_q  <= valid2_q;
    end
  end

  // R5: the assembled product and its sync bits freeze while stalled.
  assert_sum_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(prod_q) && $stable(side_q) && $stable(valid_q)));

  // R4: a valid flag needs two enabled edges to cross these stages.
  assert_sum_valid_R4: assert property (@(posedge clk) disable iff (rst)
    en |=> (valid2_q == $past(valid_in)));
endmodule

// File: rtl/pmb_pad_line.sv
// Padding register stages that stretch the latency up to the budget.
module pmb_pad_line #(
  parameter int W      = 66,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  logic [W-1:0]      dq [STAGES];
  logic [STAGES-1:0] vq;

  always_ff @(posedge clk) begin
    if (en) begin
      dq[0] <= in_data;
      for (int i = 1; i < STAGES; i++) dq[i] <= dq[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vq <= '0;
    else if (en) begin
      vq[0] <= in_valid;
      for (int i = 1; i < STAGES; i++) vq[i] <= vq[i-1];
    end
  end

  assign out_data  = dq[STAGES-1];
  assign out_valid = vq[STAGES-1];

  // R2: each padding stage moves a sample forward by exactly one enabled edge.
  assert_pad_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (vq[0] == $past(in_valid)));

  // R5: the padding stages keep their contents while stalled.
  assert_pad_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(out_data) && $stable(out_valid)));
endmodule

// File: rtl/pix_mul_budget.sv
module pix_mul_budget
  import pix_mul_pkg::*;
#(
  parameter int OP_W    = 32,
  parameter int SIDE_W  = 2,
  parameter int LATENCY = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      a,
  input  logic [OP_W-1:0]      b,
  input  logic [SIDE_W-1:0]    in_side,
  output logic                 out_valid,
  output logic [2*OP_W-1:0]    product,
  output logic [SIDE_W-1:0]    out_side
);
  localparam int PW  = 2 * OP_W;
  localparam int PAD = int'(pad_depth(LATENCY));
  localparam int BW  = PW + SIDE_W;

  if (LATENCY < int'(CORE_DEPTH)) begin : g_budget_too_small
    $fatal(1, "pix_mul_budget: LATENCY below the intrinsic pipeline depth");
  end

  logic [3:0][OP_W-1:0] pp;
  logic [SIDE_W-1:0]    side1;
  logic                 valid1;
  logic [PW-1:0]        prod3;
  logic [SIDE_W-1:0]    side3;
  logic                 valid3;

  pmb_split_stage #(.OP_W(OP_W), .SIDE_W(SIDE_W)) u_split (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
    .a(a), .b(b), .in_side(in_side),
    .pp_q(pp), .side_q(side1), .valid_q(valid1)
  );

  pmb_sum_stages #(.OP_W(OP_W), .SIDE_W(SIDE_W)) u_sum (
    .clk(clk), .rst(rst), .en(en),
    .pp_in(pp), .side_in(side1), .valid_in(valid1),
    .prod_q(prod3), .side_q(side3), .valid_q(valid3)
  );

  if (PAD > 0) begin : g_pad
    logic [BW-1:0] bundle_out;
    pmb_pad_line #(.W(BW), .STAGES(PAD)) u_pad (
      .clk(clk), .rst(rst), .en(en),
      .in_data({side3, prod3}), .in_valid(valid3),
      .out_data(bundle_out), .out_valid(out_valid)
    );
    assign product  = bundle_out[PW-1:0];
    assign out_side = bundle_out[BW-1:PW];
  end else begin : g_no_pad
    assign product   = prod3;
    assign out_side  = side3;
    assign out_valid = valid3;
  end

  // R6: after any reset edge, no result is flagged valid.
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      assert_reset_clears_R6: assert (!out_valid);
    end
  end

  // R5: at the block boundary, a stall freezes data, sync bits and valid together.
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(product) && $stable(out_side) && $stable(out_valid)));
endmodule

// File: tb/pix_mul_budget_tb.sv
module pix_mul_budget_tb;
  localparam int OW  = 32;
  localparam int SW  = 2;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          in_valid = 1'b0;
  logic [OW-1:0] a = '0;
  logic [OW-1:0] b = '0;
  logic [SW-1:0] in_side = '0;
  logic          out_valid;
  logic [2*OW-1:0] product;
  logic [SW-1:0] out_side;

  int n_tests = 0;
  int n_fail  = 0;

  pix_mul_budget #(.OP_W(OW), .SIDE_W(SW), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
    .a(a), .b(b), .in_side(in_side),
    .out_valid(out_valid), .product(product), .out_side(out_side)
  );

  always #4 clk = ~clk;

  // Expected-value delay line; it advances only on enabled edges.
  logic          mv [LAT];
  logic [OW-1:0] ma [LAT];
  logic [OW-1:0] mb [LAT];
  logic [SW-1:0] ms [LAT];
  logic          last_en  = 1'b0;
  logic          last_rst = 1'b1;

  always @(posedge clk) begin
    last_en  <= en;
    last_rst <= rst;
    if (rst) begin
      for (int i = 0; i < LAT; i++) mv[i] <= 1'b0;
    end
    if (!rst && en) begin
      for (int i = LAT - 1; i > 0; i--) begin
        mv[i] <= mv[i-1]; ma[i] <= ma[i-1]; mb[i] <= mb[i-1]; ms[i] <= ms[i-1];
      end
      mv[0] <= in_valid; ma[0] <= a; mb[0] <= b; ms[0] <= in_side;
    end
    if (!rst && !en) begin
      for (int i = 0; i < LAT; i++) mv[i] <= mv[i];
    end
  end

  logic [2*OW-1:0] snap_p;
  logic [SW-1:0]   snap_s;
  logic            snap_v;
  bit              have_snap = 1'b0;

  function automatic logic [2*OW-1:0] ref_mul(input logic [OW-1:0] x, input logic [OW-1:0] y);
    return (2*OW)'(x) * (2*OW)'(y);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [2*OW-1:0] act, input logic [2*OW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: compares outputs with the model tail.
  task automatic inspect();
    if (have_snap && !last_rst && !last_en) begin
      check(product == snap_p, "R5", "product held in stall", product, snap_p);
      check({out_valid, out_side} == {snap_v, snap_s}, "R5", "valid/side held in stall",
            (2*OW)'({out_valid, out_side}), (2*OW)'({snap_v, snap_s}));
    end
    check(out_valid == mv[LAT-1], "R4 R6", "out_valid", (2*OW)'(out_valid), (2*OW)'(mv[LAT-1]));
    if (mv[LAT-1]) begin
      check(product == ref_mul(ma[LAT-1], mb[LAT-1]), "R1 R2", "product",
            product, ref_mul(ma[LAT-1], mb[LAT-1]));
      check(out_side == ms[LAT-1], "R3", "sync bits", (2*OW)'(out_side), (2*OW)'(ms[LAT-1]));
    end
    snap_p = product; snap_s = out_side; snap_v = out_valid; have_snap = 1'b1;
  endtask

  task automatic step(input bit e, input bit v, input logic [OW-1:0] x,
                      input logic [OW-1:0] y, input logic [SW-1:0] s);
    @(negedge clk);
    inspect();
    en = e; in_valid = v; a = x; b = y; in_side = s;
  endtask

  // Issues one sample, runs LAT enabled edges, then checks the result at the port directly.
  task automatic directed(input logic [OW-1:0] x, input logic [OW-1:0] y,
                          input logic [2*OW-1:0] exp, input string req);
    step(1'b1, 1'b1, x, y, 2'b10);
    for (int i = 0; i < LAT - 1; i++) step(1'b1, 1'b0, '0, '0, 2'b00);
    @(negedge clk);
    inspect();
    check(out_valid == 1'b1, req, "directed valid", (2*OW)'(out_valid), 1);
    check(product == exp, req, "directed product", product, exp);
    check(out_side == 2'b10, "R3", "directed sync", (2*OW)'(out_side), 2);
  endtask

  function automatic logic [OW-1:0] pick_operand();
    logic [OW/2-1:0] h [2];
    for (int i = 0; i < 2; i++) begin
      case ($urandom_range(0, 3))
        0: h[i] = '0;
        1: h[i] = '1;
        default: h[i] = (OW/2)'($urandom);
      endcase
    end
    return {h[1], h[0]};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6", "reset state", (2*OW)'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // R7 corner operands, each checked LAT enabled edges after capture (R2).
    directed(32'h0, 32'hFFFF_FFFF, 64'h0, "R7");
    directed(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001, "R7");
    directed(32'h0001_0000, 32'h0001_0000, 64'h0000_0001_0000_0000, "R7");
    directed(32'hFFFF_0000, 32'h0000_FFFF, 64'h0000_FFFE_0001_0000, "R1");

    // R5: one sample, a long stall, then it must emerge after the remaining enabled edges.
    step(1'b1, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 2'b01);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 32'hDEAD_BEEF, 32'h1, 2'b11);
    for (int i = 0; i < LAT - 1; i++) step(1'b1, 1'b0, '0, '0, 2'b00);
    @(negedge clk);
    inspect();
    check(out_valid && product == ref_mul(32'h1234_5678, 32'h9ABC_DEF0), "R5",
          "latency counts enabled edges only", product, ref_mul(32'h1234_5678, 32'h9ABC_DEF0));

    // R6: fill the pipe, reset with en low, expect no valid results afterwards.
    for (int i = 0; i < LAT; i++) step(1'b1, 1'b1, pick_operand(), pick_operand(), 2'b11);
    @(negedge clk);
    inspect();
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    inspect();
    rst = 1'b0; en = 1'b1; in_valid = 1'b0;
    check(out_valid == 1'b0, "R6", "valid cleared by reset under stall", (2*OW)'(out_valid), 0);
    for (int i = 0; i < LAT; i++) begin
      step(1'b1, 1'b0, '0, '0, 2'b00);
      check(out_valid == 1'b0, "R6", "no stale result after reset", (2*OW)'(out_valid), 0);
    end

    // Random traffic with random stalls: R1 to R5 are checked on every cycle.
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 9) < 7,
           pick_operand(), pick_operand(), SW'($urandom));
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b1, 1'b0, '0, '0, 2'b00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule